// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo PCM stream from a three-wire serial audio port (bit clock, word select, serial data) and turns it into parallel left and right samples. The three port wires are brought into an oversampled system clock domain, where rising bit-clock edges are detected. A 4-bit mode code selects the framing style and the word size at run time. The three framing styles are I2S, left-justified and right-justified. The three word sizes are 16, 20 and 24 bits. The block handles frames of 32, 48 or 64 bit clocks per stereo sample.

Each completed stereo frame is presented on two 24-bit sign-extended outputs with a one-cycle valid strobe. The serial source cannot be paused, so the output has no ready input: the sink must take every strobe, and each sample pair stays on the outputs until the next strobe. The block also counts bit clocks per frame, measured between falling word-select edges. A change in that count sets a sticky framing-error flag, which the system clears with a write-zero strobe.

Top module: `sai_rx`

## Requirements
- R1: Mode code fields are as follows. Bits [3:2] select the framing: 00 I2S, 01 left-justified, 10 right-justified. Bits [1:0] select the word size: 00 24-bit, 01 20-bit, 10 16-bit. Code 0000 is therefore 24-bit I2S. Any code with 11 in either field is treated as 24-bit I2S.
- R2: In I2S framing, word select low carries the left word and high carries the right word. The MSB arrives on the second rising bit clock after a word-select change.
- R3: In left-justified framing, the MSB arrives on the first rising bit clock at which the new word-select level is seen. Low is left and high is right.
- R4: In right-justified framing, the LSB is the last bit before the word select changes. The word therefore ends at the end of the half-frame, and its start depends on the word size. Low is left and high is right.
- R5: Word select and data are sampled on rising bit-clock edges. Slot bits outside the selected word have no effect on the outputs, whatever their value.
- R6: A 16- or 20-bit word appears on its output sign-extended to 24 bits. The word is two's complement and sent MSB first.
- R7: One single-cycle valid strobe follows the completion of each right word whose left word of the same frame was captured. Between strobes both sample outputs hold their values.
- R8: Frame length is the number of rising bit clocks between falling word-select edges. The error flag is set when one frame length differs from the previous one. The first two falling edges after reset only establish a length. Constant frame lengths never set the flag.
- R9: The error flag stays set until a clear strobe is given. After the clear it reads 0.
- R10: After reset, both sample outputs are zero, and the valid strobe and the error flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low reset |
| sck_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word select |
| sd_i | input | 1 | Serial data |
| mode_i | input | 4 | Framing and word-size code |
| err_clr_i | input | 1 | Write-zero strobe clearing the error flag |
| left_o | output | 24 | Left sample, sign-extended |
| right_o | output | 24 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe per stereo frame |
| frame_err_o | output | 1 | Sticky frame-length error flag |

## Verification
Several properties are checked on every clock:
- the valid strobe never lasts two cycles;
- the sample outputs change only together with the strobe;
- 16-bit results carry a proper sign extension;
- the error flag holds unless a clear is given, and rises only on a frame boundary;
- detected bit-clock edges are never adjacent.

Whether each framing style actually lands the right bits in the right channel can only be shown by the bench. It drives pseudo-random words framed every way at 32, 48 and 64 clocks per frame, with padding filled with ones. The bench also drives length changes before and after a clear.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;
  localparam int SAMPLE_W = 24;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic [4:0] wlen;
  } mode_t;

  // Field decode of the run-time mode code; reserved values give 24-bit I2S.
  function automatic mode_t decode_mode(input logic [3:0] code);
    mode_t m;
    m.fmt  = FMT_I2S;
    m.wlen = 5'd24;
    if (code[3:2] != 2'b11 && code[1:0] != 2'b11) begin
      m.fmt = fmt_e'(code[3:2]);
      case (code[1:0])
        2'b00:   m.wlen = 5'd24;
        2'b01:   m.wlen = 5'd20;
        default: m.wlen = 5'd16;
      endcase
    end
    return m;
  endfunction

  function automatic logic [SAMPLE_W-1:0] sign_extend(input logic [SAMPLE_W-1:0] raw,
                                                      input logic [4:0] wlen);
    logic [SAMPLE_W-1:0] r;
    case (wlen)
      5'd16:   r = {{(SAMPLE_W-16){raw[15]}}, raw[15:0]};
      5'd20:   r = {{(SAMPLE_W-20){raw[19]}}, raw[19:0]};
      default: r = raw;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sai_rx_sampler.sv
module sai_rx_sampler #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic tick_o,
  output logic ws_o,
  output logic sd_o
);
  logic [SYNC:0]   sck_sh;
  logic [SYNC-1:0] ws_sh;
  logic [SYNC-1:0] sd_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sh <= '0;
      ws_sh  <= '1;
      sd_sh  <= '0;
      tick_o <= 1'b0;
      ws_o   <= 1'b1;
      sd_o   <= 1'b0;
    end else begin
      sck_sh <= {sck_sh[SYNC-1:0], sck_i};
      ws_sh  <= {ws_sh[SYNC-2:0], ws_i};
      sd_sh  <= {sd_sh[SYNC-2:0], sd_i};
      tick_o <= sck_sh[SYNC-1] & ~sck_sh[SYNC];
      ws_o   <= ws_sh[SYNC-1];
      sd_o   <= sd_sh[SYNC-1];
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R5
endmodule

// File: rtl/sai_rx_frame_mon.sv
module sai_rx_frame_mon #(
  parameter int CNT_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic ws_i,
  input  logic clr_i,
  output logic err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             ws_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic [1:0]       stage_q;
  logic             fall;
  logic             mismatch;

  assign fall     = tick_i & ws_q & ~ws_i;
  assign mismatch = fall && (stage_q == 2'd2) && (cnt_q != len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q    <= 1'b1;
      cnt_q   <= '0;
      len_q   <= '0;
      stage_q <= 2'd0;
      err_o   <= 1'b0;
    end else begin
      if (tick_i) begin
        ws_q <= ws_i;
        if (fall) cnt_q <= CNT_W'(1);
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
      end
      if (fall) begin
        if (stage_q != 2'd0) len_q <= cnt_q;
        if (stage_q != 2'd2) stage_q <= stage_q + 2'd1;
      end
      if (mismatch)   err_o <= 1'b1;
      else if (clr_i) err_o <= 1'b0;
    end
  end

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !clr_i) |=> err_o); // R9
  AST_ERR_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(fall)); // R8
endmodule

// File: rtl/sai_rx_assembler.sv
module sai_rx_assembler
  import sai_rx_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic [3:0]          mode_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  mode_t               md;
  logic                ws_raw_q, eff_q, synced_q, left_ok_q;
  logic [POS_W-1:0]    pos_q, pos_n, last_pos;
  logic [SAMPLE_W-1:0] sh_q, sh_n, left_q, cap_val;
  logic                eff_ws, ws_edge, word_end, rj_end, cap, is_right;

  always_comb begin
    md       = decode_mode(mode_i);
    // I2S is left-justified framing seen through a word select delayed one bit.
    eff_ws   = (md.fmt == FMT_I2S) ? ws_raw_q : ws_i;
    ws_edge  = eff_ws ^ eff_q;
    pos_n    = ws_edge ? '0 : ((pos_q == POS_MAX) ? pos_q : pos_q + POS_W'(1));
    sh_n     = {sh_q[SAMPLE_W-2:0], sd_i};
    last_pos = POS_W'(md.wlen) - POS_W'(1);
    word_end = tick_i && (synced_q || ws_edge) && (md.fmt != FMT_RJ) && (pos_n == last_pos);
    rj_end   = tick_i && synced_q && ws_edge && (md.fmt == FMT_RJ);
    cap      = word_end || rj_end;
    is_right = word_end ? eff_ws : ~eff_ws;
    cap_val  = sign_extend(rj_end ? sh_q : sh_n, md.wlen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_raw_q  <= 1'b1;
      eff_q     <= 1'b1;
      synced_q  <= 1'b0;
      left_ok_q <= 1'b0;
      pos_q     <= '0;
      sh_q      <= '0;
      left_q    <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i) begin
        ws_raw_q <= ws_i;
        eff_q    <= eff_ws;
        pos_q    <= pos_n;
        sh_q     <= sh_n;
        if (ws_edge) synced_q <= 1'b1;
      end
      if (cap) begin
        if (!is_right) begin
          left_q    <= cap_val;
          left_ok_q <= 1'b1;
        end else if (left_ok_q) begin
          left_o    <= left_q;
          right_o   <= cap_val;
          valid_o   <= 1'b1;
          left_ok_q <= 1'b0;
        end
      end
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(right_o) |-> valid_o); // R7
  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && md.wlen == 5'd16) |-> (right_o[SAMPLE_W-1:16] == {(SAMPLE_W-16){right_o[15]}})); // R6
endmodule

// File: rtl/sai_rx.sv
module sai_rx
  import sai_rx_pkg::*;
#(
  parameter int SYNC  = 2,
  parameter int POS_W = 6,
  parameter int CNT_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_i,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic [3:0]          mode_i,
  input  logic                err_clr_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic                frame_err_o
);
  logic tick, ws_s, sd_s;

  sai_rx_sampler #(.SYNC(SYNC)) u_sampler (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .ws_i(ws_i), .sd_i(sd_i),
    .tick_o(tick), .ws_o(ws_s), .sd_o(sd_s)
  );

  sai_rx_assembler #(.POS_W(POS_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ws_i(ws_s), .sd_i(sd_s),
    .mode_i(mode_i), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  sai_rx_frame_mon #(.CNT_W(CNT_W)) u_mon (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ws_i(ws_s),
    .clr_i(err_clr_i), .err_o(frame_err_o)
  );
endmodule

// File: tb/sai_rx_tb.sv
`timescale 1ns/1ps
module sai_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, ws = 1'b1, sd = 1'b0;
  logic [3:0]  mode = 4'b0000;
  logic        err_clr = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o, frame_err_o;

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;
  string cur_req = "R2";
  logic [47:0] exp_q[$];
  logic [31:0] seed = 32'h1234_5678;
  logic carry = 1'b1;

  always #5 clk = ~clk;

  sai_rx dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .mode_i(mode), .err_clr_i(err_clr), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o), .frame_err_o(frame_err_o)
  );

  // Model side: expected sample pairs are popped on each strobe (R5, R6, R7).
  always @(negedge clk) begin
    if (rst_n && valid_o && exp_q.size() > 0) begin
      logic [47:0] e;
      e = exp_q.pop_front();
      mon_checks += 2;
      if (left_o !== e[47:24]) begin
        mon_errors++;
        $display("FAIL %s R5 R6 left act=%h exp=%h", cur_req, left_o, e[47:24]);
      end
      if (right_o !== e[23:0]) begin
        mon_errors++;
        $display("FAIL %s R5 R6 right act=%h exp=%h", cur_req, right_o, e[23:0]);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] sx(input logic [23:0] v, input int w);
    logic [23:0] m, r;
    m = (24'h1 << w) - 24'h1;
    r = v & m;
    if (v[w-1]) r = r | ~m;
    return r;
  endfunction

  function automatic logic [23:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[30:7];
  endfunction

  task automatic put_bit(input logic w, input logic d);
    @(posedge clk); #1;
    sck = 1'b0; ws = w; sd = d;
    repeat (4) @(posedge clk);
    #1 sck = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  // fmt: 0 I2S, 1 left-justified, 2 right-justified; padding bits are ones.
  task automatic send_frame(input int fmt, input int w, input int flen,
                            input logic [23:0] l, input logic [23:0] r);
    int h;
    h = flen / 2;
    for (int j = 0; j < flen; j++) begin
      logic [23:0] ch;
      logic ljb, rjb, b;
      int p;
      ch  = (j < h) ? l : r;
      p   = j % h;
      ljb = (p < w) ? ch[w-1-p] : 1'b1;
      rjb = (p >= h - w) ? ch[h-1-p] : 1'b1;
      if (fmt == 0) begin b = carry; carry = ljb; end
      else if (fmt == 1) b = ljb;
      else b = rjb;
      put_bit(j >= h, b);
    end
  endtask

  task automatic do_reset(input logic [3:0] code);
    @(posedge clk); #1;
    rst_n = 1'b0; mode = code; sck = 1'b0; ws = 1'b1; sd = 1'b0; carry = 1'b1;
    exp_q.delete();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(left_o == 24'h0 && right_o == 24'h0, "R10 samples", left_o | right_o, 24'h0);
    chk(valid_o == 1'b0 && frame_err_o == 1'b0, "R10 flags", {22'h0, valid_o, frame_err_o}, 24'h0);
    #1 rst_n = 1'b1;
  endtask

  task automatic run_group(input logic [3:0] code, input int fmt, input int w,
                           input int flen, input string req);
    do_reset(code);
    cur_req = req;
    for (int f = 0; f < 4; f++) begin
      logic [23:0] l, r;
      l = rnd();
      r = rnd();
      if (f < 3) exp_q.push_back({sx(l, w), sx(r, w)});
      send_frame(fmt, w, flen, l, r);
    end
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, {"R7 strobes missing ", req}, 24'(exp_q.size()), 24'h0);
    chk(frame_err_o == 1'b0, {"R8 no false error ", req}, {23'h0, frame_err_o}, 24'h0);
  endtask

  task automatic burst(input int flen, input int n);
    for (int f = 0; f < n; f++) send_frame(1, 16, flen, rnd(), rnd());
    repeat (20) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks + 1);
    $finish;
  end

  initial begin
    run_group(4'b0000, 0, 24, 64, "R2 R1");  // I2S 24-bit, default code
    run_group(4'b0010, 0, 16, 32, "R2");     // I2S 16-bit, word fills slot
    run_group(4'b0000, 0, 24, 48, "R2");     // I2S 24-bit at 48
    run_group(4'b0101, 1, 20, 48, "R3");     // left-justified 20-bit
    run_group(4'b0110, 1, 16, 64, "R3");     // left-justified 16-bit
    run_group(4'b1000, 2, 24, 64, "R4");     // right-justified 24-bit
    run_group(4'b1010, 2, 16, 32, "R4");     // right-justified 16-bit
    run_group(4'b1001, 2, 20, 48, "R4");     // right-justified 20-bit
    run_group(4'b1111, 0, 24, 64, "R1 fallback");
    run_group(4'b0011, 0, 24, 48, "R1 fallback");

    // Frame-length error sequence (R8, R9)
    do_reset(4'b0110);
    cur_req = "R8";
    burst(64, 3);
    chk(frame_err_o == 1'b0, "R8 steady length", {23'h0, frame_err_o}, 24'h0);
    burst(48, 2);
    chk(frame_err_o == 1'b1, "R8 length change", {23'h0, frame_err_o}, 24'h1);
    burst(48, 2);
    chk(frame_err_o == 1'b1, "R9 sticky", {23'h0, frame_err_o}, 24'h1);
    @(posedge clk); #1 err_clr = 1'b1;
    @(posedge clk); #1 err_clr = 1'b0;
    @(negedge clk);
    chk(frame_err_o == 1'b0, "R9 cleared", {23'h0, frame_err_o}, 24'h0);
    burst(48, 2);
    chk(frame_err_o == 1'b0, "R8 steady after clear", {23'h0, frame_err_o}, 24'h0);
    burst(64, 2);
    chk(frame_err_o == 1'b1, "R8 second change", {23'h0, frame_err_o}, 24'h1);

    $display("  Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
    $finish;
  end
endmodule